// File: doc/BRIEF.md
# I2C Slave Engine with Passive Bus Monitor

This block is the slave side of an I2C port. It watches the synchronized SCL and SDA lines, finds START and STOP conditions, and shifts in the address byte. It then decides whether to acknowledge that byte. The decision depends on the 7-bit own address, a general-call policy bit and an acknowledge policy bit. Once it accepts an address, it acts as a slave receiver or a slave transmitter, depending on the direction bit. It raises an interrupt at the end of every acknowledge interval and holds SCL low until software clears that interrupt.

A monitor mode turns the engine into a passive listener. It takes every address, acknowledges nothing and never stretches the clock. It clears the direction bit internally, so every byte on the bus shows up as received data. A self-clearing return-to-inactive control sends the engine back to the unaddressed state at the next interrupt clear. A clear bit holds the engine in reset. Out of reset the clear bit is set, so the engine starts disabled.

Top module: `i2c_mon_slave`

## Requirements
- R1: After rst_ni the control register reads 0x01: the clear bit (bit 0) is set, and no line is pulled and no interrupt is pending. Bit positions: 6 return-to-inactive, 5 general-call refuse, 4 acknowledge refuse, 3 monitor, 0 clear. Bits 7, 2 and 1 read 0.
- R2: While the clear bit is 1, bus traffic addressed to the own address is neither acknowledged nor interrupted. Writing the register with bit 0 at 0 enables the engine.
- R3: With the general-call refuse bit at 0, an address byte of 0x00 is acknowledged. The interrupt rises at the SCL fall that ends the acknowledge clock.
- R4: With the general-call refuse bit at 1, an address byte of 0x00 is not acknowledged. No interrupt is raised and active_o stays 0.
- R5: An address byte whose upper seven bits equal own_addr_i is acknowledged when the acknowledge refuse bit is 0, and active_o then goes to 1. When the refuse bit is 1, it gets no acknowledge and no interrupt. A non-matching address is ignored.
- R6: As a receiver, each data byte appears on rx_data_o and raises an interrupt. It is acknowledged only if the acknowledge refuse bit is 0 when the byte's eighth bit ends.
- R7: After a read address (LSB 1) is accepted and the interrupt is cleared, tx_data_i is shifted out MSB first. A master not-acknowledge ends the transfer: after the next interrupt clear, the engine drives nothing.
- R8: From the SCL fall ending an acknowledge interval until irq_clr_i, scl_pd_o is 1 and irq_o is 1.
- R9: In monitor mode (bit 3), the engine accepts any address and acknowledges no byte. It presents the address byte with bit 0 forced to 0, then every following byte on rx_data_o, and interrupts per byte without stretching SCL.
- R10: A return-to-inactive bit written as 1 sends the engine to the inactive state at the next interrupt clear, and the bit then reads 0. active_o is unchanged.
- R11: A STOP returns the engine to idle and clears active_o. A START, including a repeated one, begins a new address phase.
- R12: sda_pd_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| scl_pd_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pd_o | output | 1 | Pull SDA low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| own_addr_i | input | 7 | Own slave address |
| rx_data_o | output | 8 | Last received byte |
| tx_data_i | input | 8 | Byte to transmit, loaded at interrupt clear |
| irq_clr_i | input | 1 | Clear pending interrupt, release SCL |
| irq_o | output | 1 | Interrupt pending |
| active_o | output | 1 | Addressed since last STOP |

## Verification
The hardest state to reach is the end of a slave-transmit transfer. The master has to not-acknowledge while the engine is stretching the clock, and an interrupt clear must then leave both lines released. The bench models the bus as a wired AND of a scripted master and the two pull-downs. This lets the master's clock wait out the stretch. The bench then runs a read address, one acknowledged byte and one refused byte. The same wired bus lets a repeated START be issued straight after a stretched acknowledge, which shows that the address phase restarts.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam int CTL_RTI = 6;
  localparam int CTL_GCN = 5;
  localparam int CTL_NAK = 4;
  localparam int CTL_MON = 3;
  localparam int CTL_CLR = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_TX, ST_ACK, ST_MACK, ST_HOLD
  } st_e;
endpackage

// File: rtl/i2c_mon_edges.sv
module i2c_mon_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_mon_ctrl.sv
module i2c_mon_ctrl
  import i2c_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rti_consume_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rti_o,
  output logic              gcn_o,
  output logic              nak_o,
  output logic              mon_o,
  output logic              clr_o
);
  logic rti_q, gcn_q, nak_q, mon_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rti_q <= 1'b0;
      gcn_q <= 1'b0;
      nak_q <= 1'b0;
      mon_q <= 1'b0;
      clr_q <= 1'b1;
    end else if (we_i) begin
      rti_q <= wdata_i[CTL_RTI];
      gcn_q <= wdata_i[CTL_GCN];
      nak_q <= wdata_i[CTL_NAK];
      mon_q <= wdata_i[CTL_MON];
      clr_q <= wdata_i[CTL_CLR];
    end else if (rti_consume_i) begin
      rti_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[CTL_RTI] = rti_q;
    rdata_o[CTL_GCN] = gcn_q;
    rdata_o[CTL_NAK] = nak_q;
    rdata_o[CTL_MON] = mon_q;
    rdata_o[CTL_CLR] = clr_q;
  end

  assign rti_o = rti_q;
  assign gcn_o = gcn_q;
  assign nak_o = nak_q;
  assign mon_o = mon_q;
  assign clr_o = clr_q;

  // R10: consumed return-to-inactive bit reads back as 0
  a_r10_rti_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_consume_i && !we_i) |=> !rti_q);
endmodule

// File: rtl/i2c_mon_slave.sv
module i2c_mon_slave
  import i2c_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pd_o,
  output logic              sda_pd_o,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              active_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic rti, gcn, nak, mon, clr, rti_consume;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, rx_q;
  logic ack_q, rd_q, mnak_q, irq_q, active_q;
  logic clr_evt;

  i2c_mon_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_mon_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .wdata_i       (reg_wdata_i),
    .rti_consume_i (rti_consume),
    .rdata_o       (reg_rdata_o),
    .rti_o         (rti),
    .gcn_o         (gcn),
    .nak_o         (nak),
    .mon_o         (mon),
    .clr_o         (clr)
  );

  assign clr_evt     = irq_clr_i & irq_q;
  assign rti_consume = clr_evt & rti & ~clr & ~start_det & ~stop_det;

  // address decision inputs, evaluated at the end of the eighth bit
  logic addr_gc, addr_own;
  assign addr_gc  = (sh_q == '0);
  assign addr_own = (sh_q[BYTE_W-1:1] == own_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; rx_q <= '0;
      ack_q <= 1'b0; rd_q <= 1'b0; mnak_q <= 1'b0; irq_q <= 1'b0; active_q <= 1'b0;
    end else if (clr) begin
      st_q <= ST_IDLE; cnt_q <= '0; ack_q <= 1'b0; rd_q <= 1'b0;
      mnak_q <= 1'b0; irq_q <= 1'b0; active_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE; cnt_q <= '0; active_q <= 1'b0; ack_q <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_ADDR; cnt_q <= '0; ack_q <= 1'b0;
    end else begin
      if (clr_evt) begin
        irq_q <= 1'b0;
        if (!rti && st_q == ST_HOLD) begin
          cnt_q <= '0;
          if (rd_q && mnak_q) st_q <= ST_IDLE;
          else if (rd_q) begin st_q <= ST_TX; tx_q <= tx_data_i; end
          else st_q <= ST_RX;
        end
      end
      case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            cnt_q <= '0;
            if (st_q == ST_RX) begin
              rx_q  <= sh_q;
              ack_q <= ~nak & ~mon;
              st_q  <= ST_ACK;
            end else if (mon) begin
              rx_q <= {sh_q[BYTE_W-1:1], 1'b0};
              ack_q <= 1'b0; rd_q <= 1'b0; mnak_q <= 1'b0; active_q <= 1'b1;
              st_q <= ST_ACK;
            end else if ((addr_gc && !gcn) || (!addr_gc && addr_own && !nak)) begin
              rx_q <= sh_q;
              ack_q <= 1'b1; rd_q <= sh_q[0] & ~addr_gc; mnak_q <= 1'b0; active_q <= 1'b1;
              st_q <= ST_ACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          ack_q <= 1'b0;
          irq_q <= 1'b1;
          st_q  <= mon ? ST_RX : ST_HOLD;
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 1'b1;
          else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin cnt_q <= '0; st_q <= ST_MACK; end
            else tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
          end
        end
        ST_MACK: begin
          if (scl_rise) mnak_q <= sda_i;
          else if (scl_fall) begin irq_q <= 1'b1; st_q <= ST_HOLD; end
        end
        default: ;
      endcase
      if (rti_consume) st_q <= ST_IDLE;
    end
  end

  assign scl_pd_o = (st_q == ST_HOLD);
  assign sda_pd_o = (st_q == ST_ACK && ack_q) || (st_q == ST_TX && !tx_q[BYTE_W-1]);
  assign irq_o    = irq_q;
  assign active_o = active_q;
  assign rx_data_o = rx_q;

  // R2: clear bit leaves the lines released and no interrupt
  a_r2_clear_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!sda_pd_o && !scl_pd_o && !irq_o));
  // R8: clock is stretched only while an interrupt is pending
  a_r8_stretch_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pd_o |-> irq_o);
  // R3/R6: interrupt rises only at the end of an acknowledge interval
  a_r6_irq_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(st_q) == ST_ACK || $past(st_q) == ST_MACK));
  // R12: SDA drive changes only while SCL is low
  a_r12_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni || clr)
    $changed(sda_pd_o) |-> !$past(scl_i));
endmodule

// File: tb/i2c_mon_slave_tb_top.sv
module i2c_mon_slave_tb_top;
  localparam int Q = 4;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_i, sda_i, scl_pd, sda_pd;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, rx_data, tx_data = '0;
  logic irq_clr = 1'b0, irq, active;
  int n_run = 0, n_fail = 0, viol = 0;
  logic pd_prev = 1'b0, scl_prev = 1'b1;

  always #4 clk = ~clk;

  assign scl_i = scl_m & ~scl_pd;
  assign sda_i = sda_m & ~sda_pd;

  i2c_mon_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .own_addr_i(OWN),
    .rx_data_o(rx_data), .tx_data_i(tx_data), .irq_clr_i(irq_clr),
    .irq_o(irq), .active_o(active)
  );

  // R12 observer: drive edge seen while SCL was high
  always @(negedge clk) begin
    if (rst_n && sda_pd != pd_prev && scl_prev) viol++;
    pd_prev  = sda_pd;
    scl_prev = scl_i;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic wait_high(); while (!scl_i) @(negedge clk); endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic iclr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    wq();
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wait_high(); wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wait_high(); wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wait_high(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wait_high(); wq();
    acked = !sda_i;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wait_high(); wq();
      d[i] = sda_i;
      scl_m = 1'b0; wq();
    end
    sda_m = !mack; wq(); scl_m = 1'b1; wait_high(); wq();
    scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic t_reset_clear();
    logic a;
    chk("R1 reg reset", reg_rdata, 8'h01);
    chk("R1 no drive", {scl_pd, sda_pd, irq}, 3'b000);
    start_c(); send_byte({OWN, 1'b0}, a); wq();
    chk("R2 no ack in clear", a, 1'b0);
    chk("R2 no irq in clear", irq, 1'b0);
    stop_c();
    wr(8'h00);
    chk("R2 enabled", reg_rdata, 8'h00);
  endtask

  task automatic t_write();
    logic a;
    start_c(); send_byte({OWN, 1'b0}, a);
    chk("R5 own addr ack", a, 1'b1);
    chk("R5 active", active, 1'b1);
    chk("R8 stretch+irq", {scl_pd, irq}, 2'b11);
    iclr();
    chk("R8 released", {scl_pd, irq}, 2'b00);
    send_byte(8'hA5, a);
    chk("R6 data ack", a, 1'b1);
    chk("R6 rx data", rx_data, 8'hA5);
    chk("R6 irq", irq, 1'b1);
    wr(8'h10); iclr();
    send_byte(8'h3C, a);
    chk("R6 refused ack", a, 1'b0);
    chk("R6 rx data 2", rx_data, 8'h3C);
    chk("R6 irq 2", irq, 1'b1);
    iclr(); stop_c();
    chk("R11 stop clears active", active, 1'b0);
  endtask

  task automatic t_refuse();
    logic a;
    start_c(); send_byte({OWN, 1'b0}, a); wq();
    chk("R5 refused own", {a, irq, active}, 3'b000);
    stop_c(); wr(8'h00);
    start_c(); send_byte(8'h44, a); wq();
    chk("R5 other addr", {a, irq, active}, 3'b000);
    stop_c();
  endtask

  task automatic t_gcall();
    logic a;
    start_c(); send_byte(8'h00, a);
    chk("R3 gc ack", a, 1'b1);
    chk("R3 gc irq", irq, 1'b1);
    iclr(); stop_c();
    wr(8'h20);
    start_c(); send_byte(8'h00, a); wq();
    chk("R4 gc refused", {a, irq, active}, 3'b000);
    stop_c(); wr(8'h00);
  endtask

  task automatic t_read();
    logic a; logic [7:0] d;
    start_c(); send_byte({OWN, 1'b1}, a);
    chk("R7 read addr ack", a, 1'b1);
    tx_data = 8'hC3; iclr();
    recv_byte(1'b1, d);
    chk("R7 tx byte 1", d, 8'hC3);
    chk("R7 irq after byte", {irq, scl_pd}, 2'b11);
    tx_data = 8'h96; iclr();
    recv_byte(1'b0, d);
    chk("R7 tx byte 2", d, 8'h96);
    iclr(); wq();
    chk("R7 released after nak", {scl_pd, sda_pd, irq}, 3'b000);
    stop_c();
  endtask

  task automatic t_monitor();
    logic a;
    wr(8'h08);
    start_c(); send_byte({7'h77, 1'b1}, a);
    chk("R9 no ack addr", a, 1'b0);
    chk("R9 addr lsb stripped", rx_data, 8'hEE);
    chk("R9 irq no stretch", {irq, scl_pd}, 2'b10);
    send_byte(8'h11, a);
    chk("R9 no ack data", a, 1'b0);
    chk("R9 data byte", rx_data, 8'h11);
    iclr(); stop_c(); wr(8'h00);
  endtask

  task automatic t_rti();
    logic a;
    start_c(); send_byte({OWN, 1'b0}, a);
    wr(8'h40);
    chk("R10 rti set", reg_rdata, 8'h40);
    iclr();
    chk("R10 rti self clear", reg_rdata, 8'h00);
    chk("R10 active kept", active, 1'b1);
    send_byte(8'h55, a); wq();
    chk("R10 inactive after", {a, irq}, 2'b00);
    stop_c();
  endtask

  task automatic t_rstart();
    logic a;
    start_c(); send_byte({OWN, 1'b0}, a); iclr();
    start_c(); send_byte(8'h44, a); wq();
    chk("R11 restart new addr", {a, irq}, 2'b00);
    start_c(); send_byte({OWN, 1'b0}, a);
    chk("R11 restart own", a, 1'b1);
    iclr(); stop_c();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_clear();
    t_write();
    wr(8'h10); t_refuse();
    t_gcall();
    t_read();
    t_monitor();
    t_rti();
    t_rstart();
    chk("R12 sda only changes with scl low", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule